// File: doc/BRIEF.md
# Byte-Stream Video Timing Recovery

This block takes an 8-bit component video byte stream, one byte per clock at twice the pixel rate, and recovers the timing carried inside it. Four-byte reference codes mark where each active span starts and ends. The block finds those codes and decodes their field, vertical-blank and start/end flags. From them it rebuilds horizontal and vertical activity, the field indication, and horizontal and vertical sync strobes.

The block keeps a byte position within each line. Position 0 is the first byte of the end-of-active code. The horizontal sync pulse is placed at a fixed offset from position 0, and that offset depends on the line standard. The block also measures the distance between successive end codes and compares it with the standard's line length. Active bytes are passed through with a valid strobe and a tag that names the component in the repeating chroma-blue, luma, chroma-red, luma order.

A static input selects 525-line or 625-line timing. It may only change while reset is held.

Top module: `vstream_sync_dec`

## Requirements
- R1: A reference code is recognised when the bytes 0xFF, 0x00, 0x00 are followed by a byte with bit 7 set. In that fourth byte, bit 6 is the field flag F, bit 5 is the vertical-blank flag V, and bit 4 is H (1 = end of active, 0 = start of active). Each output reflects the byte that was presented one clock earlier.
- R2: After reset, every output stays low until the fourth byte of the first end code has been seen. This includes `hsync`, `hactive`, `pix_valid`, `field`, `vsync`, `vactive`, `line_err`, `pix_data` and `pix_tag`, and it holds even when a start code arrives before that.
- R3: Line position 0 is the first byte of an end code. `hsync` is high for the bytes at positions OFS to OFS+HS_W-1. OFS is 32 when `std_625`=0 and 24 when `std_625`=1, and HS_W defaults to 64.
- R4: `field` and `vsync` take the F and V values of the latest end code, and they change only with the byte at position OFS.
- R5: `vactive` is the inverse of V from the latest code of either kind. It updates with that code's fourth byte.
- R6: After a start code with V=0, `hactive` and `pix_valid` are high for the next 1440 bytes. After a start code with V=1 they stay low.
- R7: `pix_data` carries each active byte. `pix_tag` runs 0 (Cb), 1 (Y), 2 (Cr), 3 (second Y) and then repeats, restarting at 0 after every start code.
- R8: The distance between the fourth bytes of successive end codes must be 1716 bytes (`std_625`=0) or 1728 bytes (`std_625`=1). Any other distance sets `line_err`, which stays high until reset.
- R9: After a line of irregular length, the next end code restarts the line position, so `hsync` rises at position OFS of that new line.
- R10: A code that arrives while a data span is still open closes the span at the code's fourth byte. The three preamble bytes before it still count as data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock (twice the pixel rate) |
| rst_n | input | 1 | Active-low synchronous reset |
| std_625 | input | 1 | 0 selects 525-line timing, 1 selects 625-line timing; static |
| din | input | 8 | Incoming stream byte |
| hactive | output | 1 | High while active data bytes are presented |
| vactive | output | 1 | High outside vertical blanking |
| field | output | 1 | Current field, updated at the sync edge |
| hsync | output | 1 | Synthesised horizontal sync pulse |
| vsync | output | 1 | Vertical blank flag, updated at the sync edge |
| pix_data | output | 8 | Active data byte |
| pix_valid | output | 1 | `pix_data` holds an active byte |
| pix_tag | output | 2 | Component of `pix_data`: 0 Cb, 1 Y, 2 Cr, 3 second Y |
| line_err | output | 1 | Sticky flag for an unexpected line length |

## Verification
Two functions can act on the same byte: the close of a data span and the line-length check. Both fire on the fourth byte of an end code that arrives while a span is still open. The bench provokes this with a truncated line: a start code with V=0, 100 data bytes, then an end code. It checks that the three preamble bytes are still flagged as data. It then checks that the output sample following the fourth byte shows `hactive` low and `line_err` high together. Afterwards the next line is checked for a correctly placed `hsync`.

// File: rtl/vsd_pkg.sv
package vsd_pkg;

  typedef enum logic [1:0] {
    TAG_CB = 2'd0,
    TAG_YA = 2'd1,
    TAG_CR = 2'd2,
    TAG_YB = 2'd3
  } smp_tag_e;

  // choose the value that belongs to the selected line standard
  function automatic int unsigned pick_std(input logic is625,
                                           input int unsigned v525,
                                           input int unsigned v625);
    return is625 ? v625 : v525;
  endfunction

  // position p lies inside [lo, lo+len)
  function automatic logic in_window(input int unsigned p,
                                     input int unsigned lo,
                                     input int unsigned len);
    return (p >= lo) && (p < lo + len);
  endfunction

  // position the fourth byte of an end code reaches if the line had nominal length
  function automatic int unsigned code_pos_expected(input int unsigned line_len);
    return line_len + 32'd3;
  endfunction

endpackage

// File: rtl/vsd_code_det.sv
module vsd_code_det #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] din,
  output logic          code_hit,
  output logic          is_eav,
  output logic          f_bit,
  output logic          v_bit
);

  logic [DW-1:0] h1, h2, h3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h1 <= '0;
      h2 <= '0;
      h3 <= '0;
    end else begin
      h1 <= din;
      h2 <= h1;
      h3 <= h2;
    end
  end

  always_comb begin
    code_hit = (h3 == '1) && (h2 == '0) && (h1 == '0) && din[DW-1];
    f_bit    = din[DW-2];
    v_bit    = din[DW-3];
    is_eav   = din[DW-4];
  end

endmodule

// File: rtl/vsd_line_timer.sv
module vsd_line_timer
  import vsd_pkg::*;
#(
  parameter int unsigned LEN_525 = 1716,
  parameter int unsigned LEN_625 = 1728,
  parameter int unsigned OFS_525 = 32,
  parameter int unsigned OFS_625 = 24,
  parameter int unsigned HS_W    = 64,
  parameter int unsigned CW      = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic std_625,
  input  logic code_hit,
  input  logic is_eav,
  input  logic f_bit,
  input  logic v_bit,
  output logic lk_now,
  output logic locked,
  output logic eav_hit,
  output logic len_bad,
  output logic hs_lead,
  output logic hsync_q,
  output logic field_q,
  output logic vsync_q,
  output logic vactive_q,
  output logic err_q
);

  localparam logic [CW-1:0] PMAX = '1;

  logic [CW-1:0] pos;
  logic [CW-1:0] eff_pos;
  logic          pend_f, pend_v;
  logic          in_win;
  int unsigned   line_len, hs_ofs, eff32;

  always_comb begin
    line_len = pick_std(std_625, LEN_525, LEN_625);
    hs_ofs   = pick_std(std_625, OFS_525, OFS_625);
    eav_hit  = code_hit && is_eav;
    lk_now   = locked || eav_hit;
    eff_pos  = eav_hit ? CW'(3) : pos;
    eff32    = 32'(eff_pos);
    len_bad  = eav_hit && locked && (32'(pos) != code_pos_expected(line_len));
    hs_lead  = lk_now && (eff32 == hs_ofs);
    in_win   = lk_now && in_window(eff32, hs_ofs, HS_W);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos       <= '0;
      locked    <= 1'b0;
      pend_f    <= 1'b0;
      pend_v    <= 1'b0;
      hsync_q   <= 1'b0;
      field_q   <= 1'b0;
      vsync_q   <= 1'b0;
      vactive_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      if (eav_hit) begin
        locked <= 1'b1;
        pos    <= CW'(4);
        pend_f <= f_bit;
        pend_v <= v_bit;
      end else if (pos != PMAX) begin
        pos <= pos + CW'(1);
      end
      hsync_q <= in_win;
      if (hs_lead) begin
        field_q <= pend_f;
        vsync_q <= pend_v;
      end
      if (lk_now && code_hit) vactive_q <= ~v_bit;
      if (len_bad) err_q <= 1'b1;
    end
  end

endmodule

// File: rtl/vsd_sample_tag.sv
module vsd_sample_tag
  import vsd_pkg::*;
#(
  parameter int unsigned DW  = 8,
  parameter int unsigned ACT = 1440
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] din,
  input  logic          code_hit,
  input  logic          is_eav,
  input  logic          v_bit,
  input  logic          lk_now,
  output logic [DW-1:0] data_q,
  output logic          valid_q,
  output smp_tag_e      tag_q
);

  localparam int unsigned RW = $clog2(ACT + 1);

  logic [RW-1:0] rem;
  logic [1:0]    ph;
  logic          span_open, is_data, open_span;

  always_comb begin
    span_open = (rem != '0);
    is_data   = lk_now && span_open && !code_hit;
    open_span = code_hit && !is_eav && !v_bit && lk_now;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem     <= '0;
      ph      <= 2'd0;
      data_q  <= '0;
      valid_q <= 1'b0;
      tag_q   <= TAG_CB;
    end else begin
      if (code_hit) begin
        rem <= open_span ? RW'(ACT) : '0;
        ph  <= 2'd0;
      end else if (span_open) begin
        rem <= rem - RW'(1);
        ph  <= ph + 2'd1;
      end
      valid_q <= is_data;
      data_q  <= is_data ? din : '0;
      tag_q   <= is_data ? smp_tag_e'(ph) : TAG_CB;
    end
  end

endmodule

// File: rtl/vstream_sync_dec.sv
module vstream_sync_dec
  import vsd_pkg::*;
#(
  parameter int unsigned DW        = 8,
  parameter int unsigned ACT_BYTES = 1440,
  parameter int unsigned LEN_525   = 1716,
  parameter int unsigned LEN_625   = 1728,
  parameter int unsigned OFS_525   = 32,
  parameter int unsigned OFS_625   = 24,
  parameter int unsigned HS_W      = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          std_625,
  input  logic [DW-1:0] din,
  output logic          hactive,
  output logic          vactive,
  output logic          field,
  output logic          hsync,
  output logic          vsync,
  output logic [DW-1:0] pix_data,
  output logic          pix_valid,
  output logic [1:0]    pix_tag,
  output logic          line_err
);

  localparam int unsigned LEN_MAX = (LEN_625 > LEN_525) ? LEN_625 : LEN_525;
  localparam int unsigned CW      = $clog2(LEN_MAX + 8) + 1;

  // named internal events, also observed by the bound checker
  logic     code_hit, is_eav, f_bit, v_bit;
  logic     lk_now, locked, eav_hit, len_bad, hs_lead;
  logic     valid_q;
  smp_tag_e tag_q;

  vsd_code_det #(.DW(DW)) i_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .din      (din),
    .code_hit (code_hit),
    .is_eav   (is_eav),
    .f_bit    (f_bit),
    .v_bit    (v_bit)
  );

  vsd_line_timer #(
    .LEN_525 (LEN_525),
    .LEN_625 (LEN_625),
    .OFS_525 (OFS_525),
    .OFS_625 (OFS_625),
    .HS_W    (HS_W),
    .CW      (CW)
  ) i_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .std_625   (std_625),
    .code_hit  (code_hit),
    .is_eav    (is_eav),
    .f_bit     (f_bit),
    .v_bit     (v_bit),
    .lk_now    (lk_now),
    .locked    (locked),
    .eav_hit   (eav_hit),
    .len_bad   (len_bad),
    .hs_lead   (hs_lead),
    .hsync_q   (hsync),
    .field_q   (field),
    .vsync_q   (vsync),
    .vactive_q (vactive),
    .err_q     (line_err)
  );

  vsd_sample_tag #(.DW(DW), .ACT(ACT_BYTES)) i_smp (
    .clk      (clk),
    .rst_n    (rst_n),
    .din      (din),
    .code_hit (code_hit),
    .is_eav   (is_eav),
    .v_bit    (v_bit),
    .lk_now   (lk_now),
    .data_q   (pix_data),
    .valid_q  (valid_q),
    .tag_q    (tag_q)
  );

  assign hactive   = valid_q;
  assign pix_valid = valid_q;
  assign pix_tag   = tag_q;

endmodule

// File: rtl/vsd_checker.sv
module vsd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       locked,
  input logic       hs_lead,
  input logic       len_bad,
  input logic       hsync,
  input logic       hactive,
  input logic       field,
  input logic       vsync,
  input logic       vactive,
  input logic       line_err,
  input logic [1:0] pix_tag
);

  // R2: nothing leaves the block before the first end code
  p_quiet_prelock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> (!hsync && !hactive && !field && !vsync && !vactive && !line_err));

  // R3: the sync pulse only starts one clock after the offset byte
  p_hs_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsync) |-> $past(hs_lead));

  // R4: field and vertical sync move only on the sync edge
  p_field_on_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(field) || !$stable(vsync)) |-> $past(hs_lead));

  // R8: a bad length raises the flag on the next clock
  p_err_raise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    len_bad |=> line_err);

  // R8: the flag is sticky
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    line_err |=> line_err);

  // R7: every data span begins with a blue-difference sample
  p_tag_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hactive) |-> (pix_tag == 2'd0));

  // R7: within a span the tag steps by one, wrapping after four
  p_tag_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hactive && $past(hactive)) |-> (pix_tag == $past(pix_tag) + 2'd1));

endmodule

bind vstream_sync_dec vsd_checker i_vsd_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .locked   (locked),
  .hs_lead  (hs_lead),
  .len_bad  (len_bad),
  .hsync    (hsync),
  .hactive  (hactive),
  .field    (field),
  .vsync    (vsync),
  .vactive  (vactive),
  .line_err (line_err),
  .pix_tag  (pix_tag)
);

// File: tb/test_vstream_sync_dec.sv
module test_vstream_sync_dec;

  localparam int unsigned HS_W = 64;
  localparam int unsigned ACT  = 1440;

  typedef struct packed {
    logic f;
    logic v;
    logic xtra;     // one extra blanking byte makes the line too long
    logic err_exp;  // expected line_err after this line's end code
  } line_vec_t;

  localparam int NL = 7;
  localparam line_vec_t TBL [NL] = '{
    '{1'b0, 1'b1, 1'b0, 1'b0},
    '{1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b1, 1'b1, 1'b0, 1'b0},
    '{1'b0, 1'b0, 1'b1, 1'b0},
    '{1'b0, 1'b1, 1'b0, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       std_625 = 1'b0;
  logic [7:0] din = 8'h00;
  logic       hactive, vactive, field, hsync, vsync, pix_valid, line_err;
  logic [7:0] pix_data;
  logic [1:0] pix_tag;

  always #4 clk = ~clk;

  vstream_sync_dec i_vstream_sync_dec (
    .clk(clk), .rst_n(rst_n), .std_625(std_625), .din(din),
    .hactive(hactive), .vactive(vactive), .field(field), .hsync(hsync),
    .vsync(vsync), .pix_data(pix_data), .pix_valid(pix_valid),
    .pix_tag(pix_tag), .line_err(line_err)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // reference model state, written from the requirements
  logic [7:0] m_h1, m_h2, m_h3;
  bit         m_lk, m_pf, m_pv;
  int         m_dist, m_lpos, m_rem, m_ph, rise_pos;
  bit         e_hs, e_fld, e_vs, e_va, e_err, e_val, hs_prev;
  logic [1:0] e_tag;
  logic [7:0] e_dat;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_h1 = 0; m_h2 = 0; m_h3 = 0; m_lk = 0; m_pf = 0; m_pv = 0;
    m_dist = 0; m_lpos = 0; m_rem = 0; m_ph = 0; rise_pos = -1;
    e_hs = 0; e_fld = 0; e_vs = 0; e_va = 0; e_err = 0; e_val = 0;
    e_tag = 0; e_dat = 0; hs_prev = 0;
  endtask

  task automatic do_reset(input logic s625);
    @(negedge clk);
    rst_n = 1'b0; std_625 = s625; din = 8'h00;
    repeat (3) @(negedge clk);
    model_reset();
    rst_n = 1'b1;
  endtask

  // present one byte, advance the model, compare one clock later
  task automatic push(input logic [7:0] b);
    int  len, ofs;
    bit  code, eav, sav, isd;
    @(negedge clk);
    din  = b;
    len  = std_625 ? 1728 : 1716;
    ofs  = std_625 ? 24 : 32;
    code = (m_h3 == 8'hFF) && (m_h2 == 8'h00) && (m_h1 == 8'h00) && b[7];
    eav  = code && b[4];
    sav  = code && !b[4];
    m_dist++;
    if (eav && m_lk && (m_dist != len)) e_err = 1;
    if (eav) begin m_dist = 0; m_pf = b[6]; m_pv = b[5]; m_lk = 1; end
    m_lpos = m_dist + 3;
    e_hs = m_lk && (m_lpos >= ofs) && (m_lpos < ofs + HS_W);
    if (m_lk && (m_lpos == ofs)) begin e_fld = m_pf; e_vs = m_pv; end
    if (code && m_lk) e_va = !b[5];
    isd   = m_lk && (m_rem > 0) && !code;
    e_val = isd;
    e_tag = isd ? 2'(m_ph) : 2'd0;
    e_dat = isd ? b : 8'h00;
    if (code) begin
      m_rem = (sav && m_lk && !b[5]) ? ACT : 0;
      m_ph  = 0;
    end else if (m_rem > 0) begin
      m_rem--; m_ph++;
    end
    m_h3 = m_h2; m_h2 = m_h1; m_h1 = b;
    @(posedge clk);
    #1;
    chk("R3 hsync",    32'(hsync),     32'(e_hs));
    chk("R4 field",    32'(field),     32'(e_fld));
    chk("R4 vsync",    32'(vsync),     32'(e_vs));
    chk("R5 vactive",  32'(vactive),   32'(e_va));
    chk("R6 hactive",  32'(hactive),   32'(e_val));
    chk("R6 valid",    32'(pix_valid), 32'(e_val));
    chk("R7 tag",      32'(pix_tag),   32'(e_tag));
    chk("R7 data",     32'(pix_data),  32'(e_dat));
    chk("R8 line_err", 32'(line_err),  32'(e_err));
    if (hsync && !hs_prev) rise_pos = m_lpos;
    hs_prev = hsync;
  endtask

  task automatic push_code(input logic f, input logic v, input logic h);
    push(8'hFF); push(8'h00); push(8'h00);
    push({1'b1, f, v, h, 4'b0000});
  endtask

  // one line: end code, blanking, start code, ndata data bytes
  task automatic send_line(input logic f, input logic v, input int ndata, input int extra);
    int blank;
    blank = std_625 ? 288 : 276;
    push_code(f, v, 1'b1);
    for (int i = 0; i < blank - 8 + extra; i++) push((i % 2) ? 8'h10 : 8'h80);
    push_code(f, v, 1'b0);
    for (int i = 0; i < ndata; i++) push(8'h20 + 8'(i % 160));
  endtask

  task automatic walk_table();
    for (int k = 0; k < NL; k++) begin
      send_line(TBL[k].f, TBL[k].v, ACT, TBL[k].xtra ? 1 : 0);
      chk("R8 table line_err", 32'(line_err), 32'(TBL[k].err_exp));
      chk("R1 table field",    32'(field),    32'(TBL[k].f));
      chk("R1 table vsync",    32'(vsync),    32'(TBL[k].v));
      if (k == NL - 1)  // line after an irregular one: R9 resync
        chk("R9 hsync rise pos", 32'(rise_pos), std_625 ? 32'd24 : 32'd32);
    end
  endtask

  initial begin : watchdog
    #(8 * 190000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin : main
    // reset state (R2)
    repeat (2) @(negedge clk);
    #1;
    chk("R2 reset hsync",    32'(hsync),     0);
    chk("R2 reset hactive",  32'(hactive),   0);
    chk("R2 reset vactive",  32'(vactive),   0);
    chk("R2 reset line_err", 32'(line_err),  0);
    chk("R2 reset tag",      32'(pix_tag),   0);
    do_reset(1'b0);

    // before lock: a fake code without bit 7 and a start code stay silent
    for (int i = 0; i < 50; i++) push(8'h80);
    push(8'hFF); push(8'h00); push(8'h00); push(8'h10);
    chk("R1 non-code byte ignored vactive", 32'(vactive), 0);
    for (int i = 0; i < 40; i++) push(8'h80);
    push_code(1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 40; i++) push(8'h40);
    chk("R2 prelock hactive", 32'(hactive), 0);
    chk("R2 prelock valid",   32'(pix_valid), 0);
    chk("R2 prelock hsync",   32'(hsync), 0);

    // 525-line table walk
    walk_table();

    // 625-line table walk
    do_reset(1'b1);
    walk_table();

    // truncated line: span close and length error on the same byte (R10)
    do_reset(1'b1);
    send_line(1'b0, 1'b0, ACT, 0);
    send_line(1'b1, 1'b0, 100, 0);
    push(8'hFF);
    chk("R10 preamble counts as data", 32'(hactive), 1);
    push(8'h00); push(8'h00);
    chk("R10 preamble still data", 32'(pix_valid), 1);
    push(8'hD0);
    chk("R10 span closed at code", 32'(hactive), 0);
    chk("R10 length error same cycle", 32'(line_err), 1);
    for (int i = 0; i < 284; i++) push((i % 2) ? 8'h10 : 8'h80);
    push_code(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++) push(8'h55);
    chk("R9 resync hsync rise pos", 32'(rise_pos), 32'd24);
    chk("R1 field from code", 32'(field), 1);
    chk("R8 sticky error", 32'(line_err), 1);

    // reset clears the sticky flag
    do_reset(1'b0);
    @(posedge clk); #1;
    chk("R8 cleared by reset", 32'(line_err), 0);

    summary();
    $finish;
  end

endmodule